// File: doc/BRIEF.md
# Light-Load Mode Controller

This block is the per-channel mode selector of a synchronous buck controller. It decides whether the channel runs in fixed-frequency PWM or in a clock-aligned hysteretic mode for light loads. The analog comparators are outside the block and arrive as single bits:

- a switch-node polarity sample taken just before the high-side switch would turn on;
- three output-versus-reference flags: below the lower threshold, above the upper threshold, and a deep dip below the hysteretic regulation level.

All decisions are made on the cycles where the oscillator tick is high.

A change of mode needs a run of eight consecutive matching switch-node samples:

- positive samples move the block from PWM to hysteretic;
- negative samples move it back to PWM.

A deep output dip skips the count and returns the channel to PWM at once. While in hysteretic mode, the block raises a high-side request on a tick where the output is low, and drops it as soon as the output rises past the upper threshold. Every change of mode produces a one-cycle pulse that tells the driver stage to turn both switches off.

Hysteretic operation is allowed only when three conditions hold: soft-start has completed, the forced-PWM input is high, and the tracking-channel inhibit is low. Losing any of these while in hysteretic mode returns the channel to PWM.

Top module: `lightload_mode_ctl`

## Requirements
- R1: After reset, `hyst_mode`, `hs_req` and `drv_off` are 0 and the sample run count is zero.
- R2: `hyst_mode` and the run count change only on a clock edge where `tick` is 1. Inputs seen while `tick` is 0 are not counted.
- R3: In PWM mode (`hyst_mode`=0) with hysteresis allowed, the eighth consecutive tick with `sw_pos`=1 sets `hyst_mode`. Seven such ticks leave it at 0.
- R4: In PWM mode, a tick with `sw_pos`=0 restarts the positive run from zero.
- R5: In hysteretic mode, the eighth consecutive tick with `sw_pos`=0 clears `hyst_mode`. A tick with `sw_pos`=1 restarts that run from zero.
- R6: In hysteretic mode, a tick with `below_dip`=1 clears `hyst_mode` on that edge, whatever the run count.
- R7: On the edge where `hyst_mode` changes, `drv_off` goes to 1 for exactly one clock, `hs_req` goes to 0, and the run count is cleared.
- R8: `hs_req` is 1 only in hysteretic mode. It rises on a tick with `below_lo`=1 and `above_hi`=0. It falls on the first clock edge with `above_hi`=1, whether or not `tick` is high.
- R9: A tick with `ss_done`=0 keeps or returns the block to PWM mode.
- R10: A tick with `allow_hyst`=0 or `track_inh`=1 keeps or returns the block to PWM mode.
- R11: A tick on which hysteresis is not allowed clears the run count, so positive samples on either side of it do not add up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Oscillator tick, one clock wide |
| sw_pos | input | 1 | Switch-node sample is positive |
| below_lo | input | 1 | Output under lower hysteretic threshold |
| above_hi | input | 1 | Output over upper hysteretic threshold |
| below_dip | input | 1 | Output under hysteretic regulation level (deep dip) |
| ss_done | input | 1 | Soft-start complete |
| allow_hyst | input | 1 | Forced-PWM input, low blocks hysteresis |
| track_inh | input | 1 | Channel is tracking, forces PWM |
| hyst_mode | output | 1 | 1 = hysteretic mode, 0 = PWM mode |
| hs_req | output | 1 | High-side turn-on request in hysteretic mode |
| drv_off | output | 1 | One-clock both-switches-off pulse at a mode change |

## Verification
The hardest case to reach is a run count that has been cleared without any visible effect at the outputs. This happens when a disallowed tick or an opposite sample lands inside a run of seven matching samples. The stimulus builds a run of five or seven positive ticks, inserts the clearing tick, and then shows that seven more positives keep PWM while an eighth enters hysteresis. The same method, with ticks withheld for twenty clocks, shows that idle cycles neither count nor clear.

// File: rtl/lightload_mode_ctl.sv
module lightload_mode_ctl #(
  parameter int CNT_W = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic sw_pos,
  input  logic below_lo,
  input  logic above_hi,
  input  logic below_dip,
  input  logic ss_done,
  input  logic allow_hyst,
  input  logic track_inh,
  output logic hyst_mode,
  output logic hs_req,
  output logic drv_off
);
  localparam logic [CNT_W-1:0] RUN_LAST = '1;

  logic [CNT_W-1:0] run_q;
  logic allowed, match, leave, run_hit, flip;

  assign allowed = ss_done & allow_hyst & ~track_inh;
  assign match   = hyst_mode ? ~sw_pos : sw_pos;
  assign leave   = hyst_mode & (~allowed | below_dip);
  assign run_hit = allowed & match & (run_q == RUN_LAST);
  assign flip    = tick & (leave | run_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hyst_mode <= 1'b0;
      hs_req    <= 1'b0;
      drv_off   <= 1'b0;
      run_q     <= '0;
    end else begin
      drv_off <= flip;
      if (flip) begin
        hyst_mode <= ~hyst_mode;
        hs_req    <= 1'b0;
        run_q     <= '0;
      end else if (tick) begin
        run_q <= (allowed & match) ? run_q + 1'b1 : '0;
        if (hyst_mode) begin
          if (above_hi)      hs_req <= 1'b0;
          else if (below_lo) hs_req <= 1'b1;
        end
      end else if (above_hi) begin
        hs_req <= 1'b0;
      end
    end
  end
endmodule

module lightload_mode_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic sw_pos,
  input logic below_lo,
  input logic below_dip,
  input logic ss_done,
  input logic allow_hyst,
  input logic track_inh,
  input logic hyst_mode,
  input logic hs_req,
  input logic drv_off
);
  a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(hyst_mode));
  a_r3_entry_on_positive: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hyst_mode) |-> $past(tick) && $past(sw_pos));
  a_r6_dip_exit: assert property (@(posedge clk) disable iff (!rst_n)
    tick && hyst_mode && below_dip |=> !hyst_mode);
  a_r7_off_at_change: assert property (@(posedge clk) disable iff (!rst_n)
    (hyst_mode != $past(hyst_mode)) |-> drv_off && !hs_req);
  a_r8_hs_only_hyst: assert property (@(posedge clk) disable iff (!rst_n)
    hs_req |-> hyst_mode);
  a_r8_hs_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_req) |-> $past(tick) && $past(below_lo));
  a_r9_softstart_pwm: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !ss_done |=> !hyst_mode);
  a_r10_forced_pwm: assert property (@(posedge clk) disable iff (!rst_n)
    tick && (track_inh || !allow_hyst) |=> !hyst_mode);
endmodule

bind lightload_mode_ctl lightload_mode_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .sw_pos(sw_pos),
  .below_lo(below_lo), .below_dip(below_dip), .ss_done(ss_done),
  .allow_hyst(allow_hyst), .track_inh(track_inh),
  .hyst_mode(hyst_mode), .hs_req(hs_req), .drv_off(drv_off)
);

// File: tb/sim_lightload_mode_ctl.sv
module sim_lightload_mode_ctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic sw_pos = 1'b0, below_lo = 1'b0, above_hi = 1'b0, below_dip = 1'b0;
  logic ss_done = 1'b1, allow_hyst = 1'b1, track_inh = 1'b0;
  logic hyst_mode, hs_req, drv_off;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lightload_mode_ctl u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sw_pos(sw_pos),
    .below_lo(below_lo), .above_hi(above_hi), .below_dip(below_dip),
    .ss_done(ss_done), .allow_hyst(allow_hyst), .track_inh(track_inh),
    .hyst_mode(hyst_mode), .hs_req(hs_req), .drv_off(drv_off)
  );

  // fields: sw lo hi dip ss allow inh | exp mode hs off
  localparam int NV = 34;
  localparam logic [9:0] TBL [NV] = '{
    10'b1000110_000, 10'b1000110_000, 10'b1000110_000, 10'b1000110_000,
    10'b1000110_000, 10'b1000110_000, 10'b1000110_000,
    10'b0000110_000,
    10'b1000110_000, 10'b1000110_000, 10'b1000110_000, 10'b1000110_000,
    10'b1000110_000, 10'b1000110_000, 10'b1000110_000,
    10'b1000110_101,
    10'b1100110_110,
    10'b1010110_100,
    10'b0000110_100, 10'b0000110_100, 10'b0000110_100, 10'b0000110_100,
    10'b0000110_100, 10'b0000110_100, 10'b0000110_100,
    10'b1000110_100,
    10'b0000110_100, 10'b0000110_100, 10'b0000110_100, 10'b0000110_100,
    10'b0000110_100, 10'b0000110_100, 10'b0000110_100,
    10'b0000110_001
  };

  localparam logic [6:0] POS = 7'b1000110;
  localparam logic [6:0] NEG = 7'b0000110;

  task automatic chk(input string tag, input logic m, input logic hs, input logic off);
    checks++;
    if (hyst_mode !== m || hs_req !== hs || drv_off !== off) begin
      errors++;
      $display("FAIL %s: mode/hs/off got %b%b%b expected %b%b%b",
               tag, hyst_mode, hs_req, drv_off, m, hs, off);
    end
  endtask

  task automatic step(input logic [6:0] v);
    {sw_pos, below_lo, above_hi, below_dip, ss_done, allow_hyst, track_inh} = v;
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    {sw_pos, below_lo, above_hi, below_dip, track_inh} = '0;
    ss_done = 1'b1; allow_hyst = 1'b1; tick = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(1);
  endtask

  task automatic enter_hyst();
    for (int i = 0; i < 8; i++) step(POS);
    idle(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    idle(2);
    chk("R1 held in reset", 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    idle(1);
    chk("R1 after reset", 1'b0, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      step(TBL[i][9:3]);
      checks++;
      if ({hyst_mode, hs_req, drv_off} !== TBL[i][2:0]) begin
        errors++;
        $display("FAIL R3/R4/R5/R7/R8 table step %0d: got %b expected %b",
                 i, {hyst_mode, hs_req, drv_off}, TBL[i][2:0]);
      end
    end
    idle(1);
    chk("R7 off pulse is one clock", 1'b0, 1'b0, 1'b0);

    // R2: no counting without tick
    do_reset();
    for (int i = 0; i < 7; i++) step(POS);
    sw_pos = 1'b1;
    idle(20);
    chk("R2 no tick holds PWM", 1'b0, 1'b0, 1'b0);
    step(POS);
    chk("R2 eighth ticked sample enters", 1'b1, 1'b0, 1'b1);

    // R6: dip exit
    do_reset();
    enter_hyst();
    step(7'b1001110);
    chk("R6 dip forces PWM", 1'b0, 1'b0, 1'b1);

    // R8: request ends off tick
    do_reset();
    enter_hyst();
    step(7'b1100110);
    chk("R8 request raised", 1'b1, 1'b1, 1'b0);
    below_lo = 1'b0; above_hi = 1'b1;
    @(negedge clk);
    chk("R8 request cleared without tick", 1'b1, 1'b0, 1'b0);
    above_hi = 1'b0;

    // R9: soft-start
    do_reset();
    for (int i = 0; i < 10; i++) step(7'b1000010);
    chk("R9 soft-start blocks entry", 1'b0, 1'b0, 1'b0);
    enter_hyst();
    step(7'b1000010);
    chk("R9 soft-start forces exit", 1'b0, 1'b0, 1'b1);

    // R10: forced PWM and tracking inhibit
    do_reset();
    for (int i = 0; i < 10; i++) step(7'b1000100);
    chk("R10 forced PWM blocks entry", 1'b0, 1'b0, 1'b0);
    enter_hyst();
    step(7'b1000111);
    chk("R10 tracking inhibit forces exit", 1'b0, 1'b0, 1'b1);

    // R11: disallowed tick clears run
    do_reset();
    for (int i = 0; i < 5; i++) step(POS);
    step(7'b1000100);
    for (int i = 0; i < 7; i++) step(POS);
    chk("R11 run cleared by disallowed tick", 1'b0, 1'b0, 1'b0);
    step(POS);
    chk("R11 eighth after clear enters", 1'b1, 1'b0, 1'b1);

    // R1: reset from hysteretic mode
    idle(1);
    rst_n = 1'b0;
    idle(1);
    rst_n = 1'b1;
    idle(1);
    chk("R1 reset leaves hysteretic mode", 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 7; i++) step(POS);
    chk("R1 run count zero after reset", 1'b0, 1'b0, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule